// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block gathers five external interrupt lines and drives one request line towards a processor. A rising edge on a line marks that source as waiting. The request is raised only while some waiting, enabled source outranks every handler the processor is currently inside, so a running handler can only be interrupted by something more urgent. Source 4 ranks highest and source 0 lowest, and the ranking never changes.

The controller records nesting in an in-service register. It holds one bit per source: the bit of the running handler, plus the bits of every handler that handler interrupted. Two sideband pulses come from the processor. A start pulse moves the top eligible waiting source into service and reports its number. A return pulse retires only the most urgent in-service bit. Software sees the waiting, enable and in-service registers through a small memory-mapped bus. The waiting and in-service registers each have a plain read/write address, a write-one-to-set address and a write-one-to-clear address.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the waiting, enable and in-service registers are all zero, `cpu_req` is 0 and `taken_id` is 0.
- R2: A 0-to-1 transition on `irq_in[i]` sets waiting bit i on the next clock edge. A line held high does not set the bit again after it has been cleared.
- R3: The waiting register is read/write at byte offset 0x080. Writing 1s at 0x084 sets bits, and writing 1s at 0x088 clears bits. Zeros written to either alias leave bits unchanged. All three addresses read the register, and bits 31..5 read as 0.
- R4: The in-service register is read/write at 0x100, with write-one-to-set at 0x104 and write-one-to-clear at 0x108. All three addresses read the register.
- R5: The enable register is read/write at 0x0C0. Only waiting bits whose enable bit is 1 can raise `cpu_req`.
- R6: `cpu_req` is 1 exactly when the highest-numbered waiting-and-enabled source is numbered above every set in-service bit, or when no in-service bit is set.
- R7: A `hs_start` pulse while `cpu_req` is 1 sets the in-service bit of the highest eligible source and clears its waiting bit. It also loads that source number into `taken_id`. A `hs_start` pulse while `cpu_req` is 0 changes nothing.
- R8: A `hs_ret` pulse clears only the highest-numbered set in-service bit.
- R9: If an input edge and a software clear hit the same waiting bit in one cycle, the bit ends up set.
- R10: Addresses other than the seven listed read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 5 | External interrupt lines, edge detected |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 9 | Byte offset for reads and writes |
| bus_wdata | input | 5 | Write data, one bit per source |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| hs_start | input | 1 | Processor begins a handler |
| hs_ret | input | 1 | Processor returns from a handler |
| cpu_req | output | 1 | Interrupt request to the processor |
| taken_id | output | 3 | Number of the source last moved into service |

## Verification
Every cycle, the assertions check several relations. The request never rises without a waiting, enabled source. A granted start puts the winner into service and reports its number. A lone return removes exactly one in-service bit. An input edge always leaves its waiting bit set. Only the directed scenarios can show the address map and the alias semantics, the nesting order across several starts and returns, the refusal of a start without a request, and that a held-high line does not re-arm the bit.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_WAIT,
        SEL_WAIT_SET,
        SEL_WAIT_CLR,
        SEL_ENABLE,
        SEL_SVC,
        SEL_SVC_SET,
        SEL_SVC_CLR
    } reg_sel_e;

endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
    parameter int N_SRC = 5,
    localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] vec,
    output logic             any,
    output logic [ID_W-1:0]  idx
);

    // Highest set bit wins: later iterations override earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/nic_addr_dec.sv
module nic_addr_dec
    import nic_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] OFS_WAIT   = 9'h080,
    parameter logic [ADDR_W-1:0] OFS_ENABLE = 9'h0C0,
    parameter logic [ADDR_W-1:0] OFS_SVC    = 9'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if      (addr == OFS_WAIT)              sel = SEL_WAIT;
        else if (addr == OFS_WAIT + ADDR_W'(4)) sel = SEL_WAIT_SET;
        else if (addr == OFS_WAIT + ADDR_W'(8)) sel = SEL_WAIT_CLR;
        else if (addr == OFS_ENABLE)            sel = SEL_ENABLE;
        else if (addr == OFS_SVC)               sel = SEL_SVC;
        else if (addr == OFS_SVC + ADDR_W'(4))  sel = SEL_SVC_SET;
        else if (addr == OFS_SVC + ADDR_W'(8))  sel = SEL_SVC_CLR;
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC  = 5,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hs_start,
    input  logic              hs_ret,
    output logic              cpu_req,
    output logic [ID_W-1:0]   taken_id
);

    typedef struct packed {
        logic [N_SRC-1:0] wait_r;
        logic [N_SRC-1:0] en_r;
        logic [N_SRC-1:0] svc_r;
        logic [N_SRC-1:0] line_prev;
        logic [ID_W-1:0]  taken;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e         sel;
    logic [N_SRC-1:0] eligible;
    logic [N_SRC-1:0] line_rise;
    logic             elig_any, svc_any;
    logic [ID_W-1:0]  win_idx, svc_top;

    nic_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign eligible  = st_q.wait_r & st_q.en_r;
    assign line_rise = irq_in & ~st_q.line_prev;

    nic_prio_pick #(.N_SRC(N_SRC)) u_pick_wait (
        .vec (eligible),
        .any (elig_any),
        .idx (win_idx)
    );

    nic_prio_pick #(.N_SRC(N_SRC)) u_pick_svc (
        .vec (st_q.svc_r),
        .any (svc_any),
        .idx (svc_top)
    );

    assign cpu_req  = elig_any && (!svc_any || (win_idx > svc_top));
    assign taken_id = st_q.taken;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_WAIT, SEL_WAIT_SET, SEL_WAIT_CLR:
                bus_rdata[N_SRC-1:0] = st_q.wait_r;
            SEL_ENABLE:
                bus_rdata[N_SRC-1:0] = st_q.en_r;
            SEL_SVC, SEL_SVC_SET, SEL_SVC_CLR:
                bus_rdata[N_SRC-1:0] = st_q.svc_r;
            default: ;
        endcase
    end

    always_comb begin
        st_d = st_q;
        st_d.line_prev = irq_in;
        // Software access first.
        if (bus_we) begin
            unique case (sel)
                SEL_WAIT:     st_d.wait_r = bus_wdata;
                SEL_WAIT_SET: st_d.wait_r = st_q.wait_r | bus_wdata;
                SEL_WAIT_CLR: st_d.wait_r = st_q.wait_r & ~bus_wdata;
                SEL_ENABLE:   st_d.en_r   = bus_wdata;
                SEL_SVC:      st_d.svc_r  = bus_wdata;
                SEL_SVC_SET:  st_d.svc_r  = st_q.svc_r | bus_wdata;
                SEL_SVC_CLR:  st_d.svc_r  = st_q.svc_r & ~bus_wdata;
                default: ;
            endcase
        end
        // Return retires the most urgent handler in service.
        if (hs_ret && svc_any) begin
            st_d.svc_r[svc_top] = 1'b0;
        end
        // Handler start moves the winner into service.
        if (hs_start && cpu_req) begin
            st_d.svc_r[win_idx]  = 1'b1;
            st_d.wait_r[win_idx] = 1'b0;
            st_d.taken           = win_idx;
        end
        // Hardware edges win over any clear in the same cycle.
        st_d.wait_r = st_d.wait_r | line_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a request needs a waiting and enabled source.
    a_r5_req_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((st_q.wait_r & st_q.en_r) != '0));

    // R7: a granted start lands the winner in service and reports it.
    a_r7_start_sets_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_start && cpu_req) |=> st_q.svc_r[$past(win_idx)]);

    a_r7_start_reports_id: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_start && cpu_req) |=> (taken_id == $past(win_idx)));

    // R8: a lone return removes exactly one in-service bit.
    a_r8_ret_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ret && !hs_start && !bus_we && (st_q.svc_r != '0)) |=>
        ($countones(st_q.svc_r) == $countones($past(st_q.svc_r)) - 1));

    // R2 / R9: an input edge always leaves its waiting bit set.
    for (genvar g = 0; g < N_SRC; g++) begin : g_edge_chk
        a_r9_edge_sets_wait: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[g] && !st_q.line_prev[g]) |=> st_q.wait_r[g]);
    end

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_in = '0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [4:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hs_start = 1'b0;
    logic        hs_ret = 1'b0;
    logic        cpu_req;
    logic [2:0]  taken_id;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hs_start(hs_start), .hs_ret(hs_ret), .cpu_req(cpu_req),
        .taken_id(taken_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [4:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic rise(input int i);
        @(negedge clk);
        irq_in[i] = 1'b1;
        @(negedge clk);
        irq_in[i] = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); hs_start = 1'b1;
        @(negedge clk); hs_start = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); hs_ret = 1'b1;
        @(negedge clk); hs_ret = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1", 9'h080, 0);
        rd_chk("R1", 9'h0C0, 0);
        rd_chk("R1", 9'h100, 0);
        chk("R1", {31'b0, cpu_req}, 0);
        chk("R1", {29'b0, taken_id}, 0);
    endtask

    task automatic t_wait_regs();
        wr(9'h080, 5'h1F);
        rd_chk("R3", 9'h080, 32'h1F);
        wr(9'h088, 5'h05);
        rd_chk("R3", 9'h080, 32'h1A);
        rd_chk("R3", 9'h084, 32'h1A);
        rd_chk("R3", 9'h088, 32'h1A);
        wr(9'h084, 5'h01);
        rd_chk("R3", 9'h080, 32'h1B);
        chk("R5", {31'b0, cpu_req}, 0);
        wr(9'h080, 5'h00);
        rd_chk("R3", 9'h080, 0);
    endtask

    task automatic t_svc_regs();
        wr(9'h100, 5'h03);
        rd_chk("R4", 9'h100, 32'h03);
        wr(9'h104, 5'h10);
        rd_chk("R4", 9'h100, 32'h13);
        wr(9'h108, 5'h01);
        rd_chk("R4", 9'h104, 32'h12);
        rd_chk("R4", 9'h108, 32'h12);
        wr(9'h100, 5'h00);
        rd_chk("R4", 9'h100, 0);
    endtask

    task automatic t_mask();
        wr(9'h0C0, 5'h1F);
        rd_chk("R5", 9'h0C0, 32'h1F);
        rise(2);
        rd_chk("R2", 9'h080, 32'h04);
        chk("R6", {31'b0, cpu_req}, 1);
        wr(9'h0C0, 5'h1B);
        chk("R5", {31'b0, cpu_req}, 0);
        wr(9'h0C0, 5'h1F);
        chk("R5", {31'b0, cpu_req}, 1);
    endtask

    task automatic t_nest();
        pulse_start();
        rd_chk("R7", 9'h100, 32'h04);
        rd_chk("R7", 9'h080, 0);
        chk("R7", {29'b0, taken_id}, 2);
        chk("R6", {31'b0, cpu_req}, 0);
        rise(1);
        chk("R6", {31'b0, cpu_req}, 0);
        rise(3);
        rd_chk("R2", 9'h080, 32'h0A);
        chk("R6", {31'b0, cpu_req}, 1);
        pulse_start();
        rd_chk("R7", 9'h100, 32'h0C);
        rd_chk("R7", 9'h080, 32'h02);
        chk("R7", {29'b0, taken_id}, 3);
        pulse_start();
        rd_chk("R7", 9'h100, 32'h0C);
        rd_chk("R7", 9'h080, 32'h02);
        chk("R7", {29'b0, taken_id}, 3);
        pulse_ret();
        rd_chk("R8", 9'h100, 32'h04);
        chk("R6", {31'b0, cpu_req}, 0);
        pulse_ret();
        rd_chk("R8", 9'h100, 0);
        chk("R6", {31'b0, cpu_req}, 1);
        pulse_start();
        chk("R7", {29'b0, taken_id}, 1);
        rd_chk("R7", 9'h100, 32'h02);
        pulse_ret();
        rd_chk("R8", 9'h100, 0);
    endtask

    task automatic t_held_line();
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk);
        rd_chk("R2", 9'h080, 32'h01);
        wr(9'h088, 5'h01);
        @(negedge clk);
        rd_chk("R2", 9'h080, 0);
        irq_in[0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_race();
        @(negedge clk);
        irq_in[4] = 1'b1;
        bus_we = 1'b1; bus_addr = 9'h088; bus_wdata = 5'h10;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; irq_in[4] = 1'b0;
        rd_chk("R9", 9'h080, 32'h10);
        chk("R9", {31'b0, cpu_req}, 1);
        wr(9'h080, 5'h00);
    endtask

    task automatic t_unmapped();
        wr(9'h0A0, 5'h1F);
        rd_chk("R10", 9'h0A0, 0);
        rd_chk("R10", 9'h1FC, 0);
        rd_chk("R10", 9'h080, 0);
        rd_chk("R10", 9'h100, 0);
        rd_chk("R10", 9'h0C0, 32'h1F);
    endtask

    initial begin
        #1;
        t_reset();
        #20;
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_wait_regs();
        t_svc_regs();
        t_mask();
        t_nest();
        t_held_line();
        t_race();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule